// File: doc/BRIEF.md
# Lockstep Four-Way Video Packet Merger

The block combines packet streams from several camera inputs into one output stream, advancing all inputs together one frame at a time. Every input beat carries a packet kind (frame start, frame end or video line), a virtual channel tag, a payload word and a last-beat flag. The block waits until all participating inputs are ready for the same step. It then sends that step's packets one port at a time, from the lowest port number to the highest, and moves every beat of a packet through before it takes the next packet.

A mode input selects one of two output shapes. In the plain shape, every input's frame start and frame end appear on the output with their own channel tags. In the merged shape, only one frame start and one frame end go out per frame. The other ports' sync packets are accepted and thrown away. Line packets are still sent one by one, so a downstream receiver that handles a single channel sees one tall frame. That frame holds the lines of all sources, in the order they arrived. A port-enable mask selects which inputs take part.

Top module: `sync_merge`

## Requirements
- R1: Kind encoding is 2'b00 frame start, 2'b01 frame end and 2'b10 video line. No input is accepted and nothing is output until every enabled port presents a frame start at the same time.
- R2: In plain mode (mode_i=0), the frame start packets of all enabled ports are output back to back in ascending port order, each with its own channel tag and payload unchanged.
- R3: After the frame starts, lines go out in rounds: one line from each enabled port that has a line at its head, in ascending port order. A round begins only when every enabled port presents a valid head.
- R4: In plain mode, the frame end packets of all enabled ports are output in ascending port order after the last line round.
- R5: In merged mode (mode_i=1), exactly one frame start and one frame end are output per frame, taken from the lowest enabled port. The other enabled ports' sync packets are consumed and not output.
- R6: In merged mode, every line packet is output as its own packet with its channel tag and payload unchanged, even when ports use different tags.
- R7: A port whose port_en_i bit is 0 is never given in_ready_o and contributes no output. The mode and the mask are captured when the frame start group begins and hold for the whole frame.
- R8: All beats of one packet leave contiguously, and out_last_o marks the final beat. Exactly one input is consumed per output beat. Output fields stay stable while out_valid_o is high and out_ready_i is low.
- R9: A port that presents a frame end while other ports still present lines drops out of later rounds. The frame end group follows only after all remaining lines, and no line is output after a frame end until the next frame start.
- R10: Asserting rst_ni low, even in the middle of a frame, clears out_valid_o and in_ready_o. The block then waits for a new frame start on all enabled ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 plain lockstep, 1 merged single-frame |
| port_en_i | input | N_PORTS | Participating inputs |
| in_valid_i | input | N_PORTS | Beat valid per input |
| in_kind_i | input | N_PORTS*2 | Packet kind per input |
| in_vc_i | input | N_PORTS*VC_W | Virtual channel tag per input |
| in_data_i | input | N_PORTS*DATA_W | Payload per input |
| in_last_i | input | N_PORTS | Last beat of packet per input |
| in_ready_o | output | N_PORTS | Beat accepted per input |
| out_valid_o | output | 1 | Output beat valid |
| out_kind_o | output | 2 | Output packet kind |
| out_vc_o | output | VC_W | Output channel tag |
| out_data_o | output | DATA_W | Output payload |
| out_last_o | output | 1 | Last beat of output packet |
| out_ready_i | input | 1 | Downstream accepts beat |

## Verification
The bench builds the block with N_PORTS=4, VC_W=2 and DATA_W=16. Four ports allow every non-empty enable mask, including masks where port 0 is off, so the merged mode leader moves to another port. They also allow uneven line counts, where one or more ports reach the frame end early while others still send lines. The 16-bit payload is wide enough that each random beat can be told apart in the scoreboard. The two-bit tag covers distinct channels per port and shared channels.

// File: rtl/sync_merge_pkg.sv
package sync_merge_pkg;
  typedef enum logic [1:0] {
    K_FS   = 2'b00,
    K_FE   = 2'b01,
    K_LINE = 2'b10
  } kind_e;

  typedef enum logic [2:0] {
    S_WAIT,
    S_FS,
    S_ROUND,
    S_LINE,
    S_FE
  } st_e;
endpackage

// File: rtl/sync_merge_pick.sv
// Lowest set bit of mask above cur (or from bit 0 when start_i).
module sync_merge_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] cur_i,
  input  logic          start_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i] && (start_i || i > int'(cur_i))) begin
        idx_o = IW'(i);
        vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_merge_ctrl.sv
module sync_merge_ctrl import sync_merge_pkg::*; #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic [N-1:0]  port_en_i,
  input  logic [N-1:0]  head_vld_i,
  input  logic [N-1:0]  head_fs_i,
  input  logic [N-1:0]  head_fe_i,
  input  logic [N-1:0]  head_line_i,
  input  logic          beat_done_i,
  output logic [IW-1:0] cur_o,
  output logic          act_o,
  output logic          fwd_o,
  output logic          mode_o
);
  st_e           st_q, st_d;
  logic [IW-1:0] cur_q, cur_d, lead_q, lead_d;
  logic [N-1:0]  mask_q, mask_d, rnd_q, rnd_d;
  logic          mode_q, mode_d;

  logic [N-1:0]  lines, sel_mask, new_mask;
  logic          all_fs, all_vld, all_fe;
  logic [IW-1:0] nx_idx, pf_idx;
  logic          nx_vld, pf_vld;

  assign all_fs   = &(~port_en_i | (head_vld_i & head_fs_i));
  assign all_vld  = &(~mask_q | head_vld_i);
  assign all_fe   = &(~mask_q | (head_vld_i & head_fe_i));
  assign lines    = mask_q & head_vld_i & head_line_i;
  assign sel_mask = (st_q == S_LINE) ? rnd_q : mask_q;
  assign new_mask = (st_q == S_WAIT) ? port_en_i : lines;

  sync_merge_pick #(.N(N), .IW(IW)) u_step (
    .mask_i (sel_mask),
    .cur_i  (cur_q),
    .start_i(1'b0),
    .idx_o  (nx_idx),
    .vld_o  (nx_vld)
  );

  sync_merge_pick #(.N(N), .IW(IW)) u_first (
    .mask_i (new_mask),
    .cur_i  ('0),
    .start_i(1'b1),
    .idx_o  (pf_idx),
    .vld_o  (pf_vld)
  );

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    lead_d = lead_q;
    mask_d = mask_q;
    rnd_d  = rnd_q;
    mode_d = mode_q;
    unique case (st_q)
      S_WAIT: begin
        if (all_fs && pf_vld) begin
          st_d   = S_FS;
          cur_d  = pf_idx;
          lead_d = pf_idx;
          mask_d = port_en_i;
          mode_d = mode_i;
        end
      end
      S_FS, S_LINE, S_FE: begin
        if (beat_done_i) begin
          if (nx_vld) cur_d = nx_idx;
          else        st_d  = (st_q == S_FE) ? S_WAIT : S_ROUND;
        end
      end
      S_ROUND: begin
        // ports already at frame end sit out while others still have lines
        if (all_vld) begin
          if (|lines) begin
            st_d  = S_LINE;
            rnd_d = lines;
            cur_d = pf_idx;
          end else if (all_fe) begin
            st_d  = S_FE;
            cur_d = lead_q;
          end
        end
      end
      default: st_d = S_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_WAIT;
      cur_q  <= '0;
      lead_q <= '0;
      mask_q <= '0;
      rnd_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      lead_q <= lead_d;
      mask_q <= mask_d;
      rnd_q  <= rnd_d;
      mode_q <= mode_d;
    end
  end

  assign act_o  = (st_q == S_FS) || (st_q == S_LINE) || (st_q == S_FE);
  assign fwd_o  = !(mode_q && (st_q != S_LINE) && (cur_q != lead_q));
  assign cur_o  = cur_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/sync_merge_route.sv
module sync_merge_route #(
  parameter int N      = 4,
  parameter int IW     = 2,
  parameter int VC_W   = 2,
  parameter int DATA_W = 32
) (
  input  logic                     act_i,
  input  logic                     fwd_i,
  input  logic [IW-1:0]            cur_i,
  input  logic [N-1:0]             in_valid_i,
  input  logic [N-1:0][1:0]        in_kind_i,
  input  logic [N-1:0][VC_W-1:0]   in_vc_i,
  input  logic [N-1:0][DATA_W-1:0] in_data_i,
  input  logic [N-1:0]             in_last_i,
  input  logic                     out_ready_i,
  output logic [N-1:0]             in_ready_o,
  output logic                     out_valid_o,
  output logic [1:0]               out_kind_o,
  output logic [VC_W-1:0]          out_vc_o,
  output logic [DATA_W-1:0]        out_data_o,
  output logic                     out_last_o,
  output logic                     beat_done_o
);
  logic sel_vld, take;

  assign sel_vld = in_valid_i[cur_i];
  // dropped sync packets drain without downstream backpressure
  assign take    = fwd_i ? out_ready_i : 1'b1;

  for (genvar p = 0; p < N; p++) begin : g_rdy
    assign in_ready_o[p] = act_i && (cur_i == IW'(p)) && take;
  end

  assign out_valid_o = act_i && fwd_i && sel_vld;
  assign out_kind_o  = in_kind_i[cur_i];
  assign out_vc_o    = in_vc_i[cur_i];
  assign out_data_o  = in_data_i[cur_i];
  assign out_last_o  = in_last_i[cur_i];
  assign beat_done_o = act_i && sel_vld && take && in_last_i[cur_i];
endmodule

// File: rtl/sync_merge.sv
module sync_merge import sync_merge_pkg::*; #(
  parameter int N_PORTS = 4,
  parameter int VC_W    = 2,
  parameter int DATA_W  = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           mode_i,
  input  logic [N_PORTS-1:0]             port_en_i,
  input  logic [N_PORTS-1:0]             in_valid_i,
  input  logic [N_PORTS-1:0][1:0]        in_kind_i,
  input  logic [N_PORTS-1:0][VC_W-1:0]   in_vc_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] in_data_i,
  input  logic [N_PORTS-1:0]             in_last_i,
  output logic [N_PORTS-1:0]             in_ready_o,
  output logic                           out_valid_o,
  output logic [1:0]                     out_kind_o,
  output logic [VC_W-1:0]                out_vc_o,
  output logic [DATA_W-1:0]              out_data_o,
  output logic                           out_last_o,
  input  logic                           out_ready_i
);
  localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic [N_PORTS-1:0] head_fs, head_fe, head_line;
  logic [IW-1:0]      cur;
  logic               act, fwd, mode_q, beat_done;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_head
    assign head_fs[p]   = in_kind_i[p] == K_FS;
    assign head_fe[p]   = in_kind_i[p] == K_FE;
    assign head_line[p] = in_kind_i[p] == K_LINE;
  end

  sync_merge_ctrl #(.N(N_PORTS), .IW(IW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .port_en_i  (port_en_i),
    .head_vld_i (in_valid_i),
    .head_fs_i  (head_fs),
    .head_fe_i  (head_fe),
    .head_line_i(head_line),
    .beat_done_i(beat_done),
    .cur_o      (cur),
    .act_o      (act),
    .fwd_o      (fwd),
    .mode_o     (mode_q)
  );

  sync_merge_route #(.N(N_PORTS), .IW(IW), .VC_W(VC_W), .DATA_W(DATA_W)) u_route (
    .act_i      (act),
    .fwd_i      (fwd),
    .cur_i      (cur),
    .in_valid_i (in_valid_i),
    .in_kind_i  (in_kind_i),
    .in_vc_i    (in_vc_i),
    .in_data_i  (in_data_i),
    .in_last_i  (in_last_i),
    .out_ready_i(out_ready_i),
    .in_ready_o (in_ready_o),
    .out_valid_o(out_valid_o),
    .out_kind_o (out_kind_o),
    .out_vc_o   (out_vc_o),
    .out_data_o (out_data_o),
    .out_last_o (out_last_o),
    .beat_done_o(beat_done)
  );
endmodule

// File: rtl/sync_merge_chk.sv
module sync_merge_chk #(
  parameter int N      = 4,
  parameter int VC_W   = 2,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_q_i,
  input logic [N-1:0]      in_valid_i,
  input logic [N-1:0]      in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [1:0]        out_kind_o,
  input logic [VC_W-1:0]   out_vc_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_last_o
);
  logic fire, fs_seen, fe_phase;

  assign fire = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_seen  <= 1'b0;
      fe_phase <= 1'b0;
    end else if (fire) begin
      if (out_kind_o == 2'b00) begin
        fs_seen  <= 1'b1;
        fe_phase <= 1'b0;
      end else if (out_kind_o == 2'b01) begin
        fs_seen  <= 1'b0;
        fe_phase <= 1'b1;
      end
    end
  end

  AST_KIND_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_kind_o != 2'b11); // R1

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_kind_o) && $stable(out_vc_o)
    && $stable(out_data_o) && $stable(out_last_o)); // R8

  AST_SINGLE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_ready_o)); // R8

  AST_OUT_CONSUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> $countones(in_valid_i & in_ready_o) == 1); // R8

  AST_IL_ONE_FS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && out_kind_o == 2'b00 && mode_q_i |-> !fs_seen); // R5

  AST_NO_LINE_AFTER_FE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_kind_o == 2'b10 |-> !fe_phase); // R9
endmodule

bind sync_merge sync_merge_chk #(.N(N_PORTS), .VC_W(VC_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_q_i   (mode_q),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_kind_o (out_kind_o),
  .out_vc_o   (out_vc_o),
  .out_data_o (out_data_o),
  .out_last_o (out_last_o)
);

// File: tb/sync_merge_test.sv
`timescale 1ns/1ps
module sync_merge_test;
  localparam int NP = 4;
  localparam int DW = 16;
  localparam int MAXB = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_i = 1'b0;
  logic [NP-1:0] port_en_i = '1;
  logic [NP-1:0] in_valid_i = '0;
  logic [NP-1:0][1:0] in_kind_i = '0;
  logic [NP-1:0][1:0] in_vc_i = '0;
  logic [NP-1:0][DW-1:0] in_data_i = '0;
  logic [NP-1:0] in_last_i = '0;
  logic [NP-1:0] in_ready_o;
  logic out_valid_o, out_last_o;
  logic out_ready_i = 1'b0;
  logic [1:0] out_kind_o, out_vc_o;
  logic [DW-1:0] out_data_o;

  always #4 clk = ~clk;

  sync_merge #(.N_PORTS(NP), .VC_W(2), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .port_en_i(port_en_i),
    .in_valid_i(in_valid_i), .in_kind_i(in_kind_i), .in_vc_i(in_vc_i),
    .in_data_i(in_data_i), .in_last_i(in_last_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_kind_o(out_kind_o), .out_vc_o(out_vc_o),
    .out_data_o(out_data_o), .out_last_o(out_last_o), .out_ready_i(out_ready_i)
  );

  logic [1:0]    bk [NP][MAXB];
  logic [1:0]    bv [NP][MAXB];
  logic [DW-1:0] bd [NP][MAXB];
  logic          bl [NP][MAXB];
  int blen [NP];
  int bptr [NP];
  logic [20:0] ex [1024];
  int ewr, erd, epk;
  int checks = 0, errors = 0;
  logic cur_il;
  string scen_tag;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int p = 0; p < NP; p++) begin
      blen[p] = 0;
      bptr[p] = 0;
    end
    ewr = 0; erd = 0; epk = 0;
  endtask

  task automatic push(input int p, input logic [1:0] k, input logic [1:0] v, input logic l);
    bk[p][blen[p]] = k;
    bv[p][blen[p]] = v;
    bd[p][blen[p]] = DW'($urandom);
    bl[p][blen[p]] = l;
    blen[p]++;
  endtask

  task automatic exp_add(input int p, input int ix);
    ex[ewr] = {bk[p][ix], bv[p][ix], bd[p][ix], bl[p][ix]};
    ewr++;
    if (bl[p][ix]) epk++;
  endtask

  function automatic int lead_of(input logic [NP-1:0] m);
    for (int p = 0; p < NP; p++) if (m[p]) return p;
    return 0;
  endfunction

  // expected order: sync group, line rounds, sync group
  task automatic gen_frame(input logic il, input logic [NP-1:0] msk,
                           input logic [NP-1:0][2:0] nl, input logic [NP-1:0][1:0] vcs);
    int ld;
    ld = lead_of(msk);
    cur_il = il;
    for (int p = 0; p < NP; p++) if (msk[p]) begin
      int ix;
      ix = blen[p];
      push(p, 2'b00, vcs[p], 1'b1);
      if (!il || p == ld) exp_add(p, ix);
    end
    for (int r = 0; r < 8; r++)
      for (int p = 0; p < NP; p++)
        if (msk[p] && int'(nl[p]) > r) begin
          int nb;
          nb = 1 + int'($urandom % 4);
          for (int b = 0; b < nb; b++) begin
            push(p, 2'b10, vcs[p], b == nb - 1);
            exp_add(p, blen[p] - 1);
          end
        end
    for (int p = 0; p < NP; p++) if (msk[p]) begin
      int ix;
      ix = blen[p];
      push(p, 2'b01, vcs[p], 1'b1);
      if (!il || p == ld) exp_add(p, ix);
    end
  endtask

  function automatic string tag_of(input logic [1:0] k);
    if (scen_tag != "") return scen_tag;
    if (k == 2'b10) return cur_il ? "R6" : "R3";
    if (cur_il) return "R5";
    return (k == 2'b00) ? "R2" : "R4";
  endfunction

  task automatic run(input logic [NP-1:0] msk, input int hold_p, input int stop_after, input bit flip);
    int cyc, fires, lasts;
    bit bad_dis, bad_hold, vh[NP];
    cyc = 0; fires = 0; lasts = 0; bad_dis = 0; bad_hold = 0;
    for (int p = 0; p < NP; p++) vh[p] = 0;
    forever begin
      bit done;
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        if (bptr[p] < blen[p] && !(p == hold_p && cyc < 12)) begin
          in_valid_i[p] = vh[p] ? 1'b1 : ($urandom % 5 != 0);
          in_kind_i[p]  = bk[p][bptr[p]];
          in_vc_i[p]    = bv[p][bptr[p]];
          in_data_i[p]  = bd[p][bptr[p]];
          in_last_i[p]  = bl[p][bptr[p]];
        end else in_valid_i[p] = 1'b0;
      end
      out_ready_i = ($urandom % 4 != 0);
      #3;
      if (hold_p >= 0 && cyc < 12 && (out_valid_o || in_ready_o != '0)) bad_hold = 1;
      for (int p = 0; p < NP; p++) begin
        if (in_ready_o[p] && !msk[p]) bad_dis = 1;
        if (in_valid_i[p] && in_ready_o[p]) bptr[p]++;
        vh[p] = in_valid_i[p] && !in_ready_o[p];
      end
      if (out_valid_o && out_ready_i) begin
        logic [20:0] a;
        a = {out_kind_o, out_vc_o, out_data_o, out_last_o};
        if (erd < ewr) begin
          check(a == ex[erd], tag_of(ex[erd][20:19]), 32'(a), 32'(ex[erd]));
          erd++;
        end else check(1'b0, "R8", 32'(a), 32'h0);
        fires++;
        if (out_last_o) lasts++;
        if (flip && fires == 1) begin
          mode_i = ~mode_i;
          port_en_i = '1;
        end
      end
      cyc++;
      done = (erd == ewr);
      for (int p = 0; p < NP; p++) if (msk[p] && bptr[p] != blen[p]) done = 0;
      if (stop_after > 0 && fires >= stop_after) return;
      if (done) break;
      if (cyc > 4000) begin
        check(1'b0, "R8", 32'(erd), 32'(ewr));
        return;
      end
    end
    check(lasts == epk, "R8", 32'(lasts), 32'(epk));
    check(!bad_dis, "R7", 32'(bad_dis), 32'h0);
    if (hold_p >= 0) check(!bad_hold, "R1", 32'(bad_hold), 32'h0);
    for (int p = 0; p < NP; p++)
      if (!msk[p] && blen[p] > 0) check(bptr[p] == 0, "R7", 32'(bptr[p]), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    clear_all();
    scen_tag = "";
    repeat (3) @(negedge clk);
    #3;
    check(!out_valid_o && in_ready_o == '0, "R10", {30'h0, out_valid_o, |in_ready_o}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    // plain, all ports, port 3 late for its first frame start
    mode_i = 1'b0; port_en_i = 4'hF;
    gen_frame(1'b0, 4'hF, {3'd3, 3'd3, 3'd3, 3'd3}, {2'd3, 2'd2, 2'd1, 2'd0});
    gen_frame(1'b0, 4'hF, {3'd2, 3'd2, 3'd2, 3'd2}, {2'd3, 2'd2, 2'd1, 2'd0});
    run(4'hF, 3, 0, 1'b0);
    clear_all();

    // merged, shared channel
    mode_i = 1'b1;
    gen_frame(1'b1, 4'hF, {3'd3, 3'd3, 3'd3, 3'd3}, '0);
    gen_frame(1'b1, 4'hF, {3'd4, 3'd4, 3'd4, 3'd4}, '0);
    run(4'hF, -1, 0, 1'b0);
    clear_all();

    // merged, distinct channels forwarded as is
    gen_frame(1'b1, 4'hF, {3'd2, 3'd2, 3'd2, 3'd2}, {2'd0, 2'd3, 2'd1, 2'd2});
    run(4'hF, -1, 0, 1'b0);
    clear_all();

    // plain, ports 1 and 3 only, junk frame starts on disabled ports
    mode_i = 1'b0; port_en_i = 4'b1010;
    push(0, 2'b00, 2'd0, 1'b1);
    push(2, 2'b00, 2'd2, 1'b1);
    gen_frame(1'b0, 4'b1010, {3'd3, 3'd3, 3'd3, 3'd3}, {2'd3, 2'd2, 2'd1, 2'd0});
    scen_tag = "R7";
    run(4'b1010, -1, 0, 1'b0);
    clear_all();

    // uneven line counts, both modes
    scen_tag = "R9";
    port_en_i = 4'hF; mode_i = 1'b0;
    gen_frame(1'b0, 4'hF, {3'd3, 3'd2, 3'd4, 3'd1}, {2'd3, 2'd2, 2'd1, 2'd0});
    run(4'hF, -1, 0, 1'b0);
    clear_all();
    mode_i = 1'b1;
    gen_frame(1'b1, 4'hF, {3'd1, 3'd5, 3'd2, 3'd3}, '0);
    run(4'hF, -1, 0, 1'b0);
    clear_all();

    // mode and mask flipped mid-frame must not matter; leader is port 0 off
    scen_tag = "R7";
    mode_i = 1'b1; port_en_i = 4'b1010;
    push(2, 2'b00, 2'd2, 1'b1);
    gen_frame(1'b1, 4'b1010, {3'd2, 3'd2, 3'd2, 3'd2}, {2'd1, 2'd1, 2'd1, 2'd1});
    run(4'b1010, -1, 0, 1'b1);
    clear_all();

    // reset in mid frame
    scen_tag = "R10";
    mode_i = 1'b0; port_en_i = 4'hF;
    gen_frame(1'b0, 4'hF, {3'd3, 3'd3, 3'd3, 3'd3}, {2'd3, 2'd2, 2'd1, 2'd0});
    run(4'hF, -1, 6, 1'b0);
    @(negedge clk);
    rst_ni = 1'b0;
    in_valid_i = '0;
    #3;
    check(!out_valid_o && in_ready_o == '0, "R10", {30'h0, out_valid_o, |in_ready_o}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    clear_all();
    mode_i = 1'b1;
    gen_frame(1'b1, 4'hF, {3'd2, 3'd2, 3'd2, 3'd2}, '0);
    run(4'hF, -1, 0, 1'b0);
    clear_all();

    // random frames
    scen_tag = "";
    for (int s = 0; s < 8; s++) begin
      logic [NP-1:0] m;
      logic [NP-1:0][2:0] nl;
      logic [NP-1:0][1:0] vc;
      logic il;
      m  = NP'(1 + $urandom % 15);
      il = 1'($urandom % 2);
      for (int p = 0; p < NP; p++) begin
        nl[p] = 3'(1 + $urandom % 5);
        vc[p] = 2'($urandom);
      end
      mode_i = il; port_en_i = m;
      gen_frame(il, m, nl, vc);
      run(m, -1, 0, 1'b0);
      clear_all();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule